// File: doc/BRIEF.md
# DRAM Bank Access Sequencer

This block controls a single on-chip DRAM bank of 1024 rows by 2048 columns. Each column operation moves one 256-bit group. A request names a row, a column group and a direction. The sequencer then steps the bank through the row phases and the column phase. It drives the array's row, column, enable and write lines, and it returns read data from the array's data bus.

The sense amplifiers hold the last restored row and act as a one-row buffer. A request that hits the open row skips the row phases and pays only the column phase. A request that misses first discharges the bit lines, then senses the new row, then writes it back, and only then runs the column phase. Each phase lasts its own programmable number of cycles. A running energy tally charges five units for every row activation and one unit for every column operation, so software can compare access patterns.

Requests use a valid/ready handshake. The sequencer accepts one request at a time and refuses new ones until the current one has finished.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset `req_ready` is 1, `bank_phase` is 0 (idle), `rd_valid` is 0, `energy` is 0, and no row is open, so the next request, whatever its row, performs a full row cycle.
- R2: A request whose row differs from the open row passes through the phases in this order: precharge (`bank_phase`=1), readout (2), restore (3), column (4). Then it returns to idle (0). Each phase lasts exactly its configured number of cycles.
- R3: A request whose row equals the open row goes from idle straight to the column phase. It is busy for exactly `cfg_t_col` cycles.
- R4: `req_ready` is 0 in every cycle that a phase is in progress, so a request cannot be accepted while the bank is busy.
- R5: A read raises `rd_valid` for one cycle, in the cycle that follows the last column cycle. At the same time `rd_data` carries the array data for the requested row and column group.
- R6: A write captures `req_wdata` when the request is accepted. It drives `arr_we` and `arr_en` with that data during the column phase, and it raises no `rd_valid`.
- R7: Every accepted miss adds 6 to `energy` (5 for the activation, 1 for the column operation). Every accepted hit adds 1. `energy` does not change in any other cycle.
- R8: A configured phase length of 0 acts as 1 cycle.
- R9: Once a miss has restored its row, that row is the open row. A later request to the previously open row is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_t_pre | input | 8 | Precharge length in cycles |
| cfg_t_read | input | 8 | Row readout length in cycles |
| cfg_t_restore | input | 8 | Row restore length in cycles |
| cfg_t_col | input | 8 | Column phase length in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | 10 | Row address |
| req_col | input | 3 | 256-bit column group |
| req_wdata | input | 256 | Write data |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 256 | Read data |
| arr_en | output | 1 | Column operation enable to the array |
| arr_we | output | 1 | Column write enable to the array |
| arr_row | output | 10 | Row being sequenced |
| arr_col | output | 3 | Column group being accessed |
| arr_wdata | output | 256 | Write data to the array |
| arr_rdata | input | 256 | Read data from the array |
| bank_phase | output | 3 | Current phase: 0 idle, 1 precharge, 2 readout, 3 restore, 4 column |
| energy | output | 32 | Accumulated access energy in column units |

## Verification
The assertions check the legal successor of every phase on each cycle. They also check how an accepted request starts a hit or a miss, that `rd_valid` only follows a column phase, that a write enable never appears without a column enable, that a restored row becomes the open row, and that the energy tally stays still without an acceptance. Only the bench scenarios can show the exact length of each phase under different settings, including zero settings. They also show that the open row survives across hits and is replaced on a miss, that written data comes back on a later read, that the tally reaches the correct total, and that a mid-run reset closes the open row.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_PRE     = 3'd1,
      PH_READ    = 3'd2,
      PH_RESTORE = 3'd3,
      PH_COL     = 3'd4
   } phase_t;
endpackage

// File: rtl/dbs_phase_timer.sv
module dbs_phase_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_len,
   output logic          done
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_len - TW'(1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - TW'(1);
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/dbs_row_buffer.sv
module dbs_row_buffer #(
   parameter int RW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          set,
   input  logic [RW-1:0] set_row,
   input  logic [RW-1:0] lookup_row,
   output logic          hit
);
   logic          open_q;
   logic [RW-1:0] row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
      end else if (set) begin
         open_q <= 1'b1;
         row_q  <= set_row;
      end else if (clr) begin
         open_q <= 1'b0;
      end
   end

   assign hit = open_q && (row_q == lookup_row);

   // R9
   set_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> (open_q && row_q == $past(set_row)));
endmodule

// File: rtl/dbs_energy_acc.sv
module dbs_energy_acc #(
   parameter int EW  = 32,
   parameter bit SAT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          add,
   input  logic [EW-1:0] amt,
   output logic [EW-1:0] total
);
   logic [EW-1:0] total_q;
   logic [EW-1:0] next_total;

   generate
      if (SAT) begin : g_sat
         logic [EW:0] wide_sum;
         assign wide_sum   = {1'b0, total_q} + {1'b0, amt};
         assign next_total = wide_sum[EW] ? {EW{1'b1}} : wide_sum[EW-1:0];
      end else begin : g_wrap
         assign next_total = total_q + amt;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         total_q <= '0;
      else if (add)
         total_q <= next_total;
   end

   assign total = total_q;

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !add |=> $stable(total));
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
   import dbs_pkg::*;
#(
   parameter int ROWS       = 1024,
   parameter int COLS       = 2048,
   parameter int DW         = 256,
   parameter int TW         = 8,
   parameter int EW         = 32,
   parameter int ROW_ENERGY = 5,
   parameter int COL_ENERGY = 1,
   parameter bit SAT_ENERGY = 1'b1,
   localparam int GROUPS    = COLS / DW,
   localparam int RW        = $clog2(ROWS),
   localparam int CW        = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [TW-1:0] cfg_t_pre,
   input  logic [TW-1:0] cfg_t_read,
   input  logic [TW-1:0] cfg_t_restore,
   input  logic [TW-1:0] cfg_t_col,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [RW-1:0] req_row,
   input  logic [CW-1:0] req_col,
   input  logic [DW-1:0] req_wdata,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic          arr_en,
   output logic          arr_we,
   output logic [RW-1:0] arr_row,
   output logic [CW-1:0] arr_col,
   output logic [DW-1:0] arr_wdata,
   input  logic [DW-1:0] arr_rdata,
   output logic [2:0]    bank_phase,
   output logic [EW-1:0] energy
);
   localparam int NPH = 4;

   generate
      if (COLS % DW != 0 || ROWS < 2 || TW < 1) begin : g_bad_cfg
         $error("dram_bank_seq: illegal geometry or timer width");
      end
   endgenerate

   // phase lengths with zero mapped to one cycle
   logic [TW-1:0] cfg_raw [NPH];
   logic [TW-1:0] ph_len  [NPH];
   assign cfg_raw[0] = cfg_t_pre;
   assign cfg_raw[1] = cfg_t_read;
   assign cfg_raw[2] = cfg_t_restore;
   assign cfg_raw[3] = cfg_t_col;

   genvar g;
   generate
      for (g = 0; g < NPH; g++) begin : g_len
         assign ph_len[g] = (cfg_raw[g] == '0) ? TW'(1) : cfg_raw[g];
      end
   endgenerate

   phase_t        phase_q;
   logic          we_q;
   logic [RW-1:0] row_q;
   logic [CW-1:0] col_q;
   logic [DW-1:0] wdata_q;
   logic          rdv_q;
   logic [DW-1:0] rdata_q;

   logic          accept;
   logic          hit;
   logic          t_done;
   logic          t_load;
   logic [TW-1:0] t_len;

   assign req_ready = (phase_q == PH_IDLE);
   assign accept    = req_valid && req_ready;

   dbs_row_buffer #(.RW(RW)) u_rowbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (accept && !hit),
      .set        (phase_q == PH_RESTORE && t_done),
      .set_row    (row_q),
      .lookup_row (req_row),
      .hit        (hit)
   );

   always_comb begin
      t_load = 1'b0;
      t_len  = ph_len[3];
      unique case (phase_q)
         PH_IDLE: begin
            t_load = req_valid;
            t_len  = hit ? ph_len[3] : ph_len[0];
         end
         PH_PRE: begin
            t_load = t_done;
            t_len  = ph_len[1];
         end
         PH_READ: begin
            t_load = t_done;
            t_len  = ph_len[2];
         end
         PH_RESTORE: begin
            t_load = t_done;
            t_len  = ph_len[3];
         end
         default: begin
            t_load = 1'b0;
            t_len  = ph_len[3];
         end
      endcase
   end

   dbs_phase_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_len (t_len),
      .done     (t_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         we_q    <= 1'b0;
         row_q   <= '0;
         col_q   <= '0;
         wdata_q <= '0;
         rdv_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         rdv_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: if (req_valid) begin
               we_q    <= req_write;
               row_q   <= req_row;
               col_q   <= req_col;
               wdata_q <= req_wdata;
               phase_q <= hit ? PH_COL : PH_PRE;
            end
            PH_PRE:     if (t_done) phase_q <= PH_READ;
            PH_READ:    if (t_done) phase_q <= PH_RESTORE;
            PH_RESTORE: if (t_done) phase_q <= PH_COL;
            PH_COL: if (t_done) begin
               phase_q <= PH_IDLE;
               if (!we_q) begin
                  rdv_q   <= 1'b1;
                  rdata_q <= arr_rdata;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   dbs_energy_acc #(.EW(EW), .SAT(SAT_ENERGY)) u_energy (
      .clk   (clk),
      .rst_n (rst_n),
      .add   (accept),
      .amt   (hit ? EW'(COL_ENERGY) : EW'(ROW_ENERGY + COL_ENERGY)),
      .total (energy)
   );

   assign arr_en     = (phase_q == PH_COL);
   assign arr_we     = (phase_q == PH_COL) && we_q;
   assign arr_row    = row_q;
   assign arr_col    = col_q;
   assign arr_wdata  = wdata_q;
   assign rd_valid   = rdv_q;
   assign rd_data    = rdata_q;
   assign bank_phase = phase_q;

   // R2
   pre_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_PRE |=> (phase_q == PH_PRE || phase_q == PH_READ));
   // R2
   read_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_READ |=> (phase_q == PH_READ || phase_q == PH_RESTORE));
   // R2
   restore_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_RESTORE |=> (phase_q == PH_RESTORE || phase_q == PH_COL));
   // R2
   miss_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !hit) |=> phase_q == PH_PRE);
   // R3
   hit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && hit) |=> phase_q == PH_COL);
   // R4
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
   // R5
   rdv_after_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(phase_q) == PH_COL && !$past(we_q)));
   // R6
   we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> arr_en);
endmodule

// File: tb/test_dram_bank_seq.sv
`timescale 1ns/1ps
module test_dram_bank_seq;
   localparam int RW = 10;
   localparam int CW = 3;
   localparam int DW = 256;
   localparam int NV = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    t_pre = 8'd2, t_read = 8'd3, t_rest = 8'd1, t_col = 8'd4;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [RW-1:0] req_row = '0;
   logic [CW-1:0] req_col = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          arr_en, arr_we;
   logic [RW-1:0] arr_row;
   logic [CW-1:0] arr_col;
   logic [DW-1:0] arr_wdata;
   logic [DW-1:0] arr_rdata;
   logic [2:0]    bank_phase;
   logic [31:0]   energy;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dram_bank_seq i_dram_bank_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_t_pre(t_pre), .cfg_t_read(t_read), .cfg_t_restore(t_rest), .cfg_t_col(t_col),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .arr_en(arr_en), .arr_we(arr_we), .arr_row(arr_row), .arr_col(arr_col),
      .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
      .bank_phase(bank_phase), .energy(energy)
   );

   // array model: 32 slots indexed by low row bits and column group
   logic [DW-1:0] mem [32];
   logic [31:0]   written = '0;
   logic [4:0]    aidx;
   assign aidx = {arr_row[1:0], arr_col};

   function automatic logic [DW-1:0] dflt(input int i);
      return {8{32'hA5000000 + i}};
   endfunction

   always @(posedge clk) begin
      if (arr_en && arr_we) begin
         mem[aidx]     <= arr_wdata;
         written[aidx] <= 1'b1;
      end
   end
   assign arr_rdata = written[aidx] ? mem[aidx] : dflt(int'(aidx));

   function automatic logic [DW-1:0] model_at(input logic [RW-1:0] r, input logic [CW-1:0] c);
      logic [4:0] k;
      k = {r[1:0], c};
      return written[k] ? mem[k] : dflt(int'(k));
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // fields: [14] write, [13:4] row, [3:1] column group, [0] expected hit
   localparam logic [14:0] VEC [NV] = '{
      {1'b0, 10'd5,  3'd2, 1'b0},
      {1'b0, 10'd5,  3'd7, 1'b1},
      {1'b1, 10'd5,  3'd3, 1'b1},
      {1'b0, 10'd5,  3'd3, 1'b1},
      {1'b1, 10'd10, 3'd0, 1'b0},
      {1'b0, 10'd5,  3'd3, 1'b0},
      {1'b0, 10'd10, 3'd0, 1'b0},
      {1'b0, 10'd10, 3'd1, 1'b1}
   };

   longint exp_energy = 0;

   function automatic int eff(input logic [7:0] t);
      return (t == 8'd0) ? 1 : int'(t);
   endfunction

   task automatic run_req(input bit wr, input logic [RW-1:0] r, input logic [CW-1:0] c,
                          input logic [DW-1:0] wd, input bit exp_hit, input string tag);
      int busy;
      int pc [5];
      int exp_busy;
      logic [DW-1:0] exp_d;
      for (int k = 0; k < 5; k++) pc[k] = 0;
      exp_d = model_at(r, c);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_row = r; req_col = c; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      // R4: busy right after acceptance
      chk(req_ready == 1'b0, {"R4 ready low while busy ", tag}, longint'(req_ready), 0);
      busy = 0;
      while (!req_ready && busy < 2000) begin
         pc[bank_phase] = pc[bank_phase] + 1;
         busy++;
         @(negedge clk);
      end
      exp_busy = exp_hit ? eff(t_col) : eff(t_pre) + eff(t_read) + eff(t_rest) + eff(t_col);
      if (exp_hit) begin
         // R3: hit goes straight to the column phase
         chk(busy == exp_busy && pc[1] == 0, {"R3 hit latency ", tag}, busy, exp_busy);
      end else begin
         // R2: miss phase order and per-phase lengths
         chk(busy == exp_busy, {"R2 miss latency ", tag}, busy, exp_busy);
         chk(pc[1] == eff(t_pre) && pc[2] == eff(t_read) && pc[3] == eff(t_rest),
             {"R2 row phase lengths ", tag}, pc[1]*100 + pc[2]*10 + pc[3],
             eff(t_pre)*100 + eff(t_read)*10 + eff(t_rest));
      end
      chk(pc[4] == eff(t_col), {"R2 column phase length ", tag}, pc[4], eff(t_col));
      if (wr) begin
         // R6: no read strobe, array holds latched data
         chk(rd_valid == 1'b0, {"R6 no rd_valid on write ", tag}, longint'(rd_valid), 0);
         checks++;
         if (model_at(r, c) !== wd) begin
            errors++;
            $display("FAIL R6 write data %s actual=%h expected=%h", tag, model_at(r, c), wd);
         end
      end else begin
         // R5: read strobe and data
         chk(rd_valid == 1'b1, {"R5 rd_valid ", tag}, longint'(rd_valid), 1);
         checks++;
         if (rd_data !== exp_d) begin
            errors++;
            $display("FAIL R5 read data %s actual=%h expected=%h", tag, rd_data, exp_d);
         end
         @(negedge clk);
         chk(rd_valid == 1'b0, {"R5 rd_valid single cycle ", tag}, longint'(rd_valid), 0);
      end
      exp_energy += exp_hit ? 1 : 6;
      // R7: energy tally
      chk(longint'(energy) == exp_energy, {"R7 energy ", tag}, longint'(energy), exp_energy);
   endtask

   task automatic check_reset_state(input string tag);
      chk(req_ready == 1'b1, {"R1 ready ", tag}, longint'(req_ready), 1);
      chk(bank_phase == 3'd0, {"R1 phase ", tag}, longint'(bank_phase), 0);
      chk(rd_valid == 1'b0, {"R1 rd_valid ", tag}, longint'(rd_valid), 0);
      chk(energy == 32'd0, {"R1 energy ", tag}, longint'(energy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state("after power-up");

      for (int i = 0; i < NV; i++) begin
         logic [14:0] v;
         v = VEC[i];
         run_req(v[14], v[13:4], v[3:1], {8{32'hC0DE0000 + i}}, v[0],
                 $sformatf("vec%0d", i));
      end

      // R8: zero lengths behave as one cycle
      t_pre = 0; t_read = 0; t_rest = 0; t_col = 0;
      run_req(1'b0, 10'd20, 3'd1, '0, 1'b0, "R8 zero-length miss");
      run_req(1'b0, 10'd20, 3'd2, '0, 1'b1, "R8 zero-length hit");

      // R1 and R9: mid-run reset closes the open row
      t_pre = 8'd2; t_read = 8'd3; t_rest = 8'd1; t_col = 8'd4;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_energy = 0;
      check_reset_state("after mid-run reset");
      run_req(1'b0, 10'd20, 3'd1, '0, 1'b0, "R1 first access after reset misses");

      // R9: a longer row set-up with different lengths, then a hit on the new row
      t_pre = 8'd5; t_read = 8'd1; t_rest = 8'd7; t_col = 8'd2;
      run_req(1'b0, 10'd1023, 3'd7, '0, 1'b0, "R9 new row opens");
      run_req(1'b0, 10'd1023, 3'd0, '0, 1'b1, "R9 new row hit");
      run_req(1'b0, 10'd20, 3'd1, '0, 1'b0, "R9 old row now misses");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule